// File: doc/BRIEF.md
# Carry-Controlled Add/Subtract/Compare Unit

This block is the integer arithmetic slice of a small soft processor core. A combinational datapath takes two 32-bit operands and an operation code and produces a result together with a proposed next value for the carry flag. A thin registered wrapper around the datapath holds the carry flag and a second, mirrored copy of it. The stored flag feeds back as the carry-in whenever an instruction asks for it.

Subtraction is reversed: the unit computes the second operand minus the first. The two compare operations also compute that difference, but they overwrite its top bit with a sign bit taken from one of the operands. This makes the ordering readable from bit 31 alone. A byte-match search reports the position of the first equal byte, scanning from the most significant end. A keep bit on add and subtract leaves the carry state alone.

The instruction decoder drives the operation code and the two control bits every cycle. The flag update happens on the next rising clock edge.

Top module: `carry_alu`

## Requirements
- R1: With op 3'd0 (add), result_o = a_i + b_i + cin mod 2^32. cin is 0 when use_carry_i is 0, and the stored flag carry_o when use_carry_i is 1.
- R2: With op 3'd1 (reverse subtract), result_o = b_i + ~a_i + cin mod 2^32. cin is 1 when use_carry_i is 0, and carry_o when use_carry_i is 1.
- R3: For add and reverse subtract with keep_i = 0, carry_next_o is bit 32 of the 33-bit sum of the two summands and cin, and carry_we_o is 1. On the next rising clock edge, carry_o and carry_mirror_o both take that value.
- R4: For add and reverse subtract with keep_i = 1, carry_we_o is 0, and carry_o and carry_mirror_o keep their values across the clock edge. The result is unaffected by keep_i.
- R5: With op 3'd2 (signed compare), result_o is b_i - a_i. When a_i[31] differs from b_i[31], bit 31 of the result is replaced by b_i[31].
- R6: With op 3'd3 (unsigned compare), result_o is b_i - a_i. When a_i[31] differs from b_i[31], bit 31 of the result is replaced by a_i[31].
- R7: With op 3'd4 (byte find), result_o is 1 if bits 31:24 of a_i and b_i are equal. Otherwise it is 2 for bits 23:16, 3 for bits 15:8, 4 for bits 7:0, checked in that order, and 0 if no byte pair is equal.
- R8: Compare and byte find drive carry_we_o and carry_next_o to 0 and leave carry_o and carry_mirror_o unchanged, regardless of use_carry_i and keep_i.
- R9: While rst_ni is low, carry_o and carry_mirror_o are 0.
- R10: Op codes 3'd5 to 3'd7 give result_o = 0, carry_next_o = 0 and carry_we_o = 0, and leave the carry state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| use_carry_i | input | 1 | Take carry-in from the stored flag |
| keep_i | input | 1 | Suppress the carry update |
| result_o | output | 32 | Operation result |
| carry_next_o | output | 1 | Carry-out proposed for the flag |
| carry_we_o | output | 1 | Carry flag write strobe |
| carry_o | output | 1 | Stored carry flag |
| carry_mirror_o | output | 1 | Mirrored copy of the carry flag |

## Verification
Each operation is tried with the operands 0, all-ones and 0x80000000, paired in every combination, and then with random values. The corner pairs separate a correct carry at bit 32 from an off-by-one cin, and they split the sign-patch cases of both compares: equal sign bits against differing sign bits. The byte-find patterns place a single matching byte at each position, and also several matches at once, so that the scan order is distinguished from a mere any-match test. Sequences chain a carry-producing add into carry-consuming add and subtract operations, and interleave keep, compare and unused op codes between them. This shows that only an unkept add or subtract moves the flag.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_RSUB  = 3'd1,
    OP_CMP_S = 3'd2,
    OP_CMP_U = 3'd3,
    OP_BFIND = 3'd4
  } alu_op_e;
endpackage

// File: rtl/alu_add_unit.sv
module alu_add_unit #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              rsub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  logic [DATA_W-1:0] x, y;
  logic [DATA_W:0]   full;

  // reverse subtract: b + ~a + cin
  assign x = rsub_i ? b_i  : a_i;
  assign y = rsub_i ? ~a_i : b_i;
  assign full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin_i};
  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];
endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W-1:0] diff;
  logic              sign_mix;

  assign diff     = b_i + ~a_i + {{(DATA_W-1){1'b0}}, 1'b1};
  assign sign_mix = a_i[MSB] ^ b_i[MSB];

  always_comb begin
    res_o = diff;
    if (sign_mix) res_o[MSB] = signed_i ? b_i[MSB] : a_i[MSB];
  end
endmodule

// File: rtl/alu_byte_find.sv
module alu_byte_find #(
  parameter int DATA_W = 32,
  localparam int N_BYTES = DATA_W / 8,
  localparam int POS_W = $clog2(N_BYTES + 1)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [POS_W-1:0]  pos_o
);
  logic [N_BYTES-1:0] hit;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    assign hit[g] = (a_i[g*8 +: 8] == b_i[g*8 +: 8]);
  end

  // ascending scan: the highest byte lane that matches wins
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      if (hit[i]) pos_o = POS_W'(N_BYTES - i);
    end
  end
endmodule

// File: rtl/alu_carry_reg.sv
module alu_carry_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o,
  output logic q_mirror_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o        <= 1'b0;
      q_mirror_o <= 1'b0;
    end else if (we_i) begin
      q_o        <= d_i;
      q_mirror_o <= d_i;
    end
  end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
  import carry_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              use_carry_i,
  input  logic              keep_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_next_o,
  output logic              carry_we_o,
  output logic              carry_o,
  output logic              carry_mirror_o
);
  localparam int N_BYTES = DATA_W / 8;
  localparam int POS_W   = $clog2(N_BYTES + 1);

  alu_op_e           op;
  logic              is_arith, is_rsub, cin;
  logic [DATA_W-1:0] sum, cmp_res;
  logic              cout;
  logic [POS_W-1:0]  pos;

  assign op       = alu_op_e'(op_i);
  assign is_rsub  = (op == OP_RSUB);
  assign is_arith = (op == OP_ADD) || is_rsub;
  // default cin: 0 for add, 1 for reverse subtract
  assign cin      = use_carry_i ? carry_o : is_rsub;

  alu_add_unit #(.DATA_W(DATA_W)) u_add (
    .a_i(a_i), .b_i(b_i), .rsub_i(is_rsub), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  alu_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
    .a_i(a_i), .b_i(b_i), .signed_i(op == OP_CMP_S), .res_o(cmp_res)
  );

  alu_byte_find #(.DATA_W(DATA_W)) u_find (
    .a_i(a_i), .b_i(b_i), .pos_o(pos)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_RSUB:   result_o = sum;
      OP_CMP_S, OP_CMP_U: result_o = cmp_res;
      OP_BFIND:          result_o = {{(DATA_W-POS_W){1'b0}}, pos};
      default:           result_o = '0;
    endcase
  end

  assign carry_next_o = is_arith & cout;
  assign carry_we_o   = is_arith & ~keep_i;

  alu_carry_reg u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(carry_we_o), .d_i(carry_next_o),
    .q_o(carry_o), .q_mirror_o(carry_mirror_o)
  );
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              use_carry_i,
  input logic              keep_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_next_o,
  input logic              carry_we_o,
  input logic              carry_o,
  input logic              carry_mirror_o
);
  a_r1_add_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 && !use_carry_i) |-> result_o == a_i + b_i);

  a_r2_rsub_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && !use_carry_i) |-> result_o == b_i - a_i);

  a_r3_flag_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_we_o |=> carry_o == $past(carry_next_o));

  a_r3_mirror_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == carry_mirror_o);

  a_r4_keep_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_i |=> $stable(carry_o) && $stable(carry_mirror_o));

  a_r8_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {3'd2, 3'd3, 3'd4}) |-> !carry_we_o && !carry_next_o);

  a_r7_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4) |-> result_o <= DATA_W'(DATA_W / 8));

  a_r10_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 3'd4) |-> result_o == '0 && !carry_we_o);

  always_comb begin
    if (!rst_ni) a_r9_reset_clear: assert (!carry_o && !carry_mirror_o);
  end
endmodule

bind carry_alu carry_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .use_carry_i(use_carry_i), .keep_i(keep_i), .result_o(result_o),
  .carry_next_o(carry_next_o), .carry_we_o(carry_we_o),
  .carry_o(carry_o), .carry_mirror_o(carry_mirror_o)
);

// File: tb/carry_alu_tb.sv
module carry_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        use_carry_i = 1'b0, keep_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_next_o, carry_we_o, carry_o, carry_mirror_o;

  int n_checks = 0;
  int n_err = 0;
  bit model_flag = 1'b0;
  bit done = 1'b0;

  carry_alu u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .use_carry_i(use_carry_i), .keep_i(keep_i), .result_o(result_o),
    .carry_next_o(carry_next_o), .carry_we_o(carry_we_o),
    .carry_o(carry_o), .carry_mirror_o(carry_mirror_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive one operation, check combinational outputs, then the flag after the edge.
  task automatic run_op(string tag, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                        logic uc, logic k);
    logic [32:0] full;
    logic [31:0] exp_res;
    logic        exp_next, exp_we, cin;
    exp_res = '0; exp_next = 1'b0; exp_we = 1'b0;
    case (op)
      3'd0, 3'd1: begin
        cin  = uc ? model_flag : (op == 3'd1);
        full = (op == 3'd0) ? ({1'b0, a} + {1'b0, b} + {32'd0, cin})
                            : ({1'b0, b} + {1'b0, ~a} + {32'd0, cin});
        exp_res = full[31:0]; exp_next = full[32]; exp_we = !k;
      end
      3'd2, 3'd3: begin
        exp_res = b - a;
        if (a[31] != b[31]) exp_res[31] = (op == 3'd2) ? b[31] : a[31];
      end
      3'd4: begin
        for (int i = 0; i < 4; i++) begin
          if (exp_res == 0 && a[31-8*i -: 8] == b[31-8*i -: 8]) exp_res = 32'(i + 1);
        end
      end
      default: ;
    endcase
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; use_carry_i = uc; keep_i = k;
    #1;
    chk({tag, " result"}, result_o, exp_res);
    chk({tag, " next"}, {31'd0, carry_next_o}, {31'd0, exp_next});
    chk({tag, " we"}, {31'd0, carry_we_o}, {31'd0, exp_we});
    @(posedge clk_i);
    #1;
    if (exp_we) model_flag = exp_next;
    chk({tag, " flag"}, {31'd0, carry_o}, {31'd0, model_flag});
    chk({tag, " mirror"}, {31'd0, carry_mirror_o}, {31'd0, model_flag});
  endtask

  task automatic t_reset();
    #1;
    chk("R9 reset flag", {31'd0, carry_o}, 32'd0);
    chk("R9 reset mirror", {31'd0, carry_mirror_o}, 32'd0);
  endtask

  task automatic t_corners();
    logic [31:0] cv [3] = '{32'h0, 32'hffff_ffff, 32'h8000_0000};
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++) begin
          string tg;
          case (op)
            0: tg = "R1"; 1: tg = "R2"; 2: tg = "R5"; default: tg = "R6";
          endcase
          run_op(tg, 3'(op), cv[i], cv[j], 1'b0, 1'b0);
        end
  endtask

  task automatic t_carry_chain();
    run_op("R3 set", 3'd0, 32'hffff_ffff, 32'h1, 1'b0, 1'b0);
    run_op("R1 use", 3'd0, 32'h5, 32'h7, 1'b1, 1'b1);
    run_op("R2 use", 3'd1, 32'h9, 32'h4, 1'b1, 1'b0);
    run_op("R2 use0", 3'd1, 32'h1, 32'h1, 1'b1, 1'b0);
    run_op("R3 set2", 3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
    run_op("R4 keep", 3'd1, 32'h3, 32'h1, 1'b0, 1'b1);
    run_op("R4 keep add", 3'd0, 32'h1, 32'h1, 1'b0, 1'b1);
  endtask

  task automatic t_no_write();
    run_op("R3 set3", 3'd0, 32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0);
    run_op("R8 cmps", 3'd2, 32'h1, 32'h2, 1'b1, 1'b0);
    run_op("R8 cmpu", 3'd3, 32'hffff_ffff, 32'h0, 1'b0, 1'b0);
    run_op("R8 find", 3'd4, 32'h0, 32'h0, 1'b1, 1'b0);
    for (int op = 5; op < 8; op++)
      run_op("R10 unused", 3'(op), 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0);
  endtask

  task automatic t_find();
    run_op("R7 none", 3'd4, 32'h1122_3344, 32'h5566_7788, 1'b0, 1'b0);
    run_op("R7 b3", 3'd4, 32'hAA00_0000, 32'hAA11_1111, 1'b0, 1'b0);
    run_op("R7 b2", 3'd4, 32'h00BB_0000, 32'h11BB_1111, 1'b0, 1'b0);
    run_op("R7 b1", 3'd4, 32'h0000_CC00, 32'h1111_CC11, 1'b0, 1'b0);
    run_op("R7 b0", 3'd4, 32'h0000_00DD, 32'h1111_11DD, 1'b0, 1'b0);
    run_op("R7 multi", 3'd4, 32'h00BB_CCDD, 32'h11BB_CCDD, 1'b0, 1'b0);
    run_op("R7 all", 3'd4, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 200; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 4));
      run_op("R1 R2 R5 R6 R7 rand", op, $urandom, (n % 3 == 0) ? $urandom & 32'hff00ff00 : $urandom,
             1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    #(CLK_PERIOD * 2);
    rst_ni = 1'b1;
    t_corners();
    t_carry_chain();
    t_no_write();
    t_find();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule